// File: doc/BRIEF.md
# Static Interconnect Test Sequencer

This block runs on the controller side of a memory interface. It checks the board wiring to one or more attached memory devices before those devices are initialized. When `start_i` arrives, it issues the test-mode entry sequence on the column strobe, the chip selects and the clock enable. It then steps through a fixed set of static vectors on the address and control test inputs. For each device in turn, it waits an access delay after each vector and samples the shared data bus. It compares the sample with an expected word that it computes from the vector.

Each device gets its own results: a pass flag, the index of the first vector that mismatched, the XOR of the expected and received words at that vector, and a flag that marks a probable missing device. When the test ends, the block raises the column strobe to leave test mode, so that normal initialization can follow. All delays are derived from a clock-period parameter.

Top module: `ict_host_seq`

## Requirements
- R1: After reset, and while idle, the outputs are as follows: `cas_n_o`=1, every `cs_n_o` bit 1, `cke_o`=1, `vec_o`=0, `busy_o`=0, `done_o`=0, and every `pass_o`/`miss_o` bit is 0.
- R2: Mode entry:
  - In the first cycle after `start_i` is accepted, every select is low, `cke_o` is low and `cas_n_o` is high.
  - For the next HOLD_CYC cycles, `cas_n_o` is low with every select still low and `cke_o` still low.
  - HOLD_CYC = ceil((T_HOLD_NS+T_ETD_NS)/CLK_NS), with a minimum of 1.
- R3: During the test phase, `cas_n_o` is 0, `cke_o` is 1 and exactly one select is low. Device 0 is tested first, and the devices follow in increasing index.
- R4: For each device, the block applies vectors 0 to 2*N_IN+1, in order:
  - index 0 is all zeros;
  - index 1+k is a walking one on bit k;
  - index N_IN+1+k is a walking zero on bit k;
  - the last index is all ones.
  Each vector is held for ACC_CYC = ceil(T_ACC_NS/CLK_NS) cycles (minimum 1), and the bus is sampled at the end of that window.
- R5: The expected bus word for vector v has bit j = NOT(v[j mod N_IN] XOR v[(j+1) mod N_IN]).
- R6: After a run, `pass_o[d]` is 1 exactly when every sample of device d equals its expected word.
- R7: `fail_idx_o` slice d holds the index of the first mismatching vector of device d. `diff_o` slice d holds the expected XOR received word at that vector. Both slices are 0 when device d passes.
- R8: `miss_o[d]` is set when device d returns an all-ones bus on any walking vector.
- R9: Exit and handshake:
  - After the last sample, the block spends one cycle with `cas_n_o`=1, all selects high and `cke_o`=1.
  - `busy_o` is high for exactly 2+HOLD_CYC+N_DEV*(2*N_IN+2)*ACC_CYC cycles.
  - `done_o` pulses for one cycle immediately after `busy_o` falls.
- R10: `start_i` has no effect while `busy_o` is high. An accepted start clears the previous results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a test run when idle |
| dq_i | input | DQ_W | Sampled memory data bus |
| cas_n_o | output | 1 | Column strobe, active low (mode entry and exit) |
| cs_n_o | output | N_DEV | Per-device chip selects, active low |
| cke_o | output | 1 | Clock enable (selects test vs entry) |
| vec_o | output | N_IN | Static test vector on the address and control lines |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| pass_o | output | N_DEV | Per-device pass flag |
| miss_o | output | N_DEV | Per-device probable-missing flag |
| fail_idx_o | output | N_DEV*IDX_W | Per-device first failing vector index |
| diff_o | output | N_DEV*DQ_W | Per-device expected XOR received word at the first failure |

## Verification
Any fault in the sequencer's state, device counter or vector counter appears on the pins within one cycle:
- a wrong state shows as a select pattern that is not one-hot, or as `cke_o` at the wrong level;
- a miscounted vector index shows as a wrong vector on `vec_o`;
- a miscounted hold window shifts the moment `busy_o` falls.

Faults in result capture appear only at `done_o`. They show as a wrong pass flag, index or difference word for the device whose bus response was corrupted. For that reason, the bench sets stuck-at faults and missing devices on known bits, and predicts the first failing vector for each case.

// File: rtl/ict_pkg.sv
package ict_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_ENTRY, ST_APPLY, ST_EXIT
  } ict_state_e;

  function automatic int ceil_div(input int num, input int den);
    int r;
    r = (num + den - 1) / den;
    return (r < 1) ? 1 : r;
  endfunction
endpackage

// File: rtl/ict_pattern.sv
module ict_pattern #(
  parameter int N_IN  = 20,
  parameter int DQ_W  = 32,
  parameter int N_VEC = 2 * N_IN + 2,
  parameter int IDX_W = $clog2(N_VEC)
) (
  input  logic [IDX_W-1:0] idx_i,
  output logic [N_IN-1:0]  vec_o,
  output logic [DQ_W-1:0]  exp_o,
  output logic             walk_o
);
  int k;
  assign k = int'(idx_i);

  always_comb begin
    for (int b = 0; b < N_IN; b++) begin
      vec_o[b] = (k == N_VEC - 1) || (k == b + 1) ||
                 ((k > N_IN) && (k < N_VEC - 1) && (k != N_IN + b + 1));
    end
  end

  // response rule: xnor of two neighbouring inputs
  always_comb begin
    for (int j = 0; j < DQ_W; j++) begin
      exp_o[j] = ~(vec_o[j % N_IN] ^ vec_o[(j + 1) % N_IN]);
    end
  end

  assign walk_o = (k >= 1) && (k <= 2 * N_IN);
endmodule

// File: rtl/ict_seq.sv
module ict_seq
  import ict_pkg::*;
#(
  parameter int N_DEV    = 2,
  parameter int N_VEC    = 42,
  parameter int HOLD_CYC = 1,
  parameter int ACC_CYC  = 2,
  localparam int IDX_W   = $clog2(N_VEC),
  localparam int DEV_W   = (N_DEV > 1) ? $clog2(N_DEV) : 1,
  localparam int CNT_MAX = (HOLD_CYC > ACC_CYC) ? HOLD_CYC : ACC_CYC,
  localparam int CNT_W   = $clog2(CNT_MAX + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             cas_n_o,
  output logic [N_DEV-1:0] cs_n_o,
  output logic             cke_o,
  output logic             apply_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             clr_o,
  output logic             sample_o,
  output logic [DEV_W-1:0] dev_o,
  output logic [IDX_W-1:0] idx_o
);
  ict_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [DEV_W-1:0] dev_q;
  logic [IDX_W-1:0] idx_q;
  logic             done_q;

  logic last_cnt;
  assign last_cnt = (cnt_q == CNT_W'(ACC_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      dev_q   <= '0;
      idx_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_SETUP;
          cnt_q   <= '0;
          dev_q   <= '0;
          idx_q   <= '0;
        end
        ST_SETUP: state_q <= ST_ENTRY;
        ST_ENTRY: begin
          if (cnt_q == CNT_W'(HOLD_CYC - 1)) begin
            state_q <= ST_APPLY;
            cnt_q   <= '0;
          end else cnt_q <= cnt_q + 1'b1;
        end
        ST_APPLY: begin
          if (last_cnt) begin
            cnt_q <= '0;
            if (idx_q == IDX_W'(N_VEC - 1)) begin
              idx_q <= '0;
              if (dev_q == DEV_W'(N_DEV - 1)) state_q <= ST_EXIT;
              else dev_q <= dev_q + 1'b1;
            end else idx_q <= idx_q + 1'b1;
          end else cnt_q <= cnt_q + 1'b1;
        end
        ST_EXIT: begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // pin decode
  always_comb begin
    cas_n_o = 1'b1;
    cke_o   = 1'b1;
    cs_n_o  = '1;
    unique case (state_q)
      ST_SETUP: begin cs_n_o = '0; cke_o = 1'b0; end
      ST_ENTRY: begin cs_n_o = '0; cke_o = 1'b0; cas_n_o = 1'b0; end
      ST_APPLY: begin
        cas_n_o = 1'b0;
        for (int d = 0; d < N_DEV; d++) cs_n_o[d] = (dev_q != DEV_W'(d));
      end
      default: ;
    endcase
  end

  assign apply_o  = (state_q == ST_APPLY);
  assign busy_o   = (state_q != ST_IDLE);
  assign done_o   = done_q;
  assign clr_o    = (state_q == ST_IDLE) && start_i;
  assign sample_o = apply_o && last_cnt;
  assign dev_o    = dev_q;
  assign idx_o    = idx_q;

  p_entry_pins_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_ENTRY |-> (!cas_n_o && !cke_o && cs_n_o == '0));
  p_one_select_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    apply_o |-> ($countones(~cs_n_o) == 1 && cke_o));
  p_vec_held_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (apply_o && cnt_q != '0) |-> $stable(idx_q));
  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_exit_to_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_EXIT |=> (!busy_o && done_o));
  p_busy_ignores_start_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && state_q != ST_EXIT) |=> state_q != ST_SETUP);
endmodule

// File: rtl/ict_result.sv
module ict_result #(
  parameter int DQ_W  = 32,
  parameter int IDX_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             smp_i,
  input  logic             walk_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [DQ_W-1:0]  exp_i,
  input  logic [DQ_W-1:0]  got_i,
  output logic             pass_o,
  output logic             miss_o,
  output logic [IDX_W-1:0] fail_idx_o,
  output logic [DQ_W-1:0]  diff_o
);
  logic seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pass_o     <= 1'b0;
      miss_o     <= 1'b0;
      seen_q     <= 1'b0;
      fail_idx_o <= '0;
      diff_o     <= '0;
    end else if (clr_i) begin
      pass_o     <= 1'b1;
      miss_o     <= 1'b0;
      seen_q     <= 1'b0;
      fail_idx_o <= '0;
      diff_o     <= '0;
    end else if (smp_i) begin
      if (got_i != exp_i && !seen_q) begin
        seen_q     <= 1'b1;
        pass_o     <= 1'b0;
        fail_idx_o <= idx_i;
        diff_o     <= got_i ^ exp_i;
      end
      if (walk_i && &got_i) miss_o <= 1'b1;
    end
  end

  p_first_kept_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && !clr_i) |=> ($stable(fail_idx_o) && $stable(diff_o)));
  p_fail_has_diff_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q |-> diff_o != '0);
endmodule

// File: rtl/ict_host_seq.sv
module ict_host_seq
  import ict_pkg::*;
#(
  parameter int N_DEV     = 2,
  parameter int N_IN      = 20,
  parameter int DQ_W      = 32,
  parameter int CLK_NS    = 10,
  parameter int T_HOLD_NS = 5,
  parameter int T_ETD_NS  = 5,
  parameter int T_ACC_NS  = 20,
  localparam int N_VEC    = 2 * N_IN + 2,
  localparam int IDX_W    = $clog2(N_VEC),
  localparam int DEV_W    = (N_DEV > 1) ? $clog2(N_DEV) : 1,
  localparam int HOLD_CYC = ceil_div(T_HOLD_NS + T_ETD_NS, CLK_NS),
  localparam int ACC_CYC  = ceil_div(T_ACC_NS, CLK_NS)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic [DQ_W-1:0]        dq_i,
  output logic                   cas_n_o,
  output logic [N_DEV-1:0]       cs_n_o,
  output logic                   cke_o,
  output logic [N_IN-1:0]        vec_o,
  output logic                   busy_o,
  output logic                   done_o,
  output logic [N_DEV-1:0]       pass_o,
  output logic [N_DEV-1:0]       miss_o,
  output logic [N_DEV*IDX_W-1:0] fail_idx_o,
  output logic [N_DEV*DQ_W-1:0]  diff_o
);
  logic             apply, clr, sample, walk;
  logic [DEV_W-1:0] dev;
  logic [IDX_W-1:0] idx;
  logic [N_IN-1:0]  vec;
  logic [DQ_W-1:0]  exp_w;

  ict_seq #(
    .N_DEV(N_DEV), .N_VEC(N_VEC), .HOLD_CYC(HOLD_CYC), .ACC_CYC(ACC_CYC)
  ) u_seq (
    .clk_i, .rst_ni, .start_i,
    .cas_n_o, .cs_n_o, .cke_o,
    .apply_o(apply), .busy_o, .done_o, .clr_o(clr),
    .sample_o(sample), .dev_o(dev), .idx_o(idx)
  );

  ict_pattern #(.N_IN(N_IN), .DQ_W(DQ_W), .N_VEC(N_VEC), .IDX_W(IDX_W)) u_pat (
    .idx_i(idx), .vec_o(vec), .exp_o(exp_w), .walk_o(walk)
  );

  assign vec_o = apply ? vec : '0;

  for (genvar d = 0; d < N_DEV; d++) begin : g_res
    ict_result #(.DQ_W(DQ_W), .IDX_W(IDX_W)) u_res (
      .clk_i, .rst_ni,
      .clr_i(clr),
      .smp_i(sample && dev == DEV_W'(d)),
      .walk_i(walk),
      .idx_i(idx),
      .exp_i(exp_w),
      .got_i(dq_i),
      .pass_o(pass_o[d]),
      .miss_o(miss_o[d]),
      .fail_idx_o(fail_idx_o[d*IDX_W +: IDX_W]),
      .diff_o(diff_o[d*DQ_W +: DQ_W])
    );
  end

  p_idle_pins_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (cas_n_o && cke_o && cs_n_o == '1 && vec_o == '0));
endmodule

// File: tb/ict_host_seq_tb_top.sv
module ict_host_seq_tb_top;
  localparam int CLK_NS = 10;
  localparam int N_DEV  = 2;
  localparam int N_IN   = 20;
  localparam int DQ_W   = 32;
  localparam int N_VEC  = 2 * N_IN + 2;
  localparam int IDX_W  = $clog2(N_VEC);
  localparam int HOLD_C = (10 + CLK_NS - 1) / CLK_NS;
  localparam int ACC_C  = (20 + CLK_NS - 1) / CLK_NS;
  localparam int BUSY_C = 2 + HOLD_C + N_DEV * N_VEC * ACC_C;

  logic clk = 0, rst_ni = 0, start = 0;
  logic [DQ_W-1:0] dq;
  logic cas_n, cke, busy, done;
  logic [N_DEV-1:0] cs_n, pass, miss;
  logic [N_IN-1:0] vec;
  logic [N_DEV*IDX_W-1:0] fidx;
  logic [N_DEV*DQ_W-1:0] diff;

  int checks = 0, errors = 0;
  logic [DQ_W-1:0] s1 [N_DEV];
  logic [DQ_W-1:0] s0 [N_DEV];
  logic present [N_DEV];

  always #(CLK_NS/2) clk = ~clk;

  ict_host_seq #(.N_DEV(N_DEV), .N_IN(N_IN), .DQ_W(DQ_W), .CLK_NS(CLK_NS)) dut_i (
    .clk_i(clk), .rst_ni, .start_i(start), .dq_i(dq),
    .cas_n_o(cas_n), .cs_n_o(cs_n), .cke_o(cke), .vec_o(vec),
    .busy_o(busy), .done_o(done), .pass_o(pass), .miss_o(miss),
    .fail_idx_o(fidx), .diff_o(diff)
  );

  function automatic logic [N_IN-1:0] gen_vec(input int i);
    logic [N_IN-1:0] v;
    if (i == 0) v = '0;
    else if (i <= N_IN) begin v = '0; v[i-1] = 1'b1; end
    else if (i <= 2 * N_IN) begin v = '1; v[i-N_IN-1] = 1'b0; end
    else v = '1;
    return v;
  endfunction

  function automatic logic [DQ_W-1:0] exp_of(input logic [N_IN-1:0] v);
    logic [DQ_W-1:0] e;
    for (int j = 0; j < DQ_W; j++) e[j] = ~(v[j % N_IN] ^ v[(j + 1) % N_IN]);
    return e;
  endfunction

  function automatic logic [DQ_W-1:0] dev_resp(input int d, input logic [N_IN-1:0] v);
    if (!present[d]) return '1;
    return (exp_of(v) | s1[d]) & ~s0[d];
  endfunction

  // memory model: one selected device drives bus, else pulled high
  always_comb begin
    dq = '1;
    for (int d = 0; d < N_DEV; d++)
      if (!cs_n[d] && cke && !cas_n) dq = dev_resp(d, vec);
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic run(input bit timing, input bit mid_start);
    int bcnt = 0;
    bit tok = 1;
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    if (timing) begin
      chk("R2 setup", {cas_n, cke, cs_n}, {1'b1, 1'b0, {N_DEV{1'b0}}});
      for (int h = 0; h < HOLD_C; h++) begin
        @(negedge clk);
        chk("R2 hold", {cas_n, cke, cs_n}, {1'b0, 1'b0, {N_DEV{1'b0}}});
      end
      for (int d = 0; d < N_DEV; d++)
        for (int v = 0; v < N_VEC; v++)
          for (int c = 0; c < ACC_C; c++) begin
            @(negedge clk);
            if ({cas_n, cke, cs_n} !== {1'b0, 1'b1, ~N_DEV'(1 << d)} || vec !== gen_vec(v)) tok = 0;
          end
      chk("R3 R4 test phase pins and vector order", 64'(tok), 64'd1);
      @(negedge clk);
      chk("R9 exit pins", {busy, cas_n, cke, cs_n}, {1'b1, 1'b1, 1'b1, {N_DEV{1'b1}}});
      @(negedge clk);
      chk("R9 done after busy", {busy, done}, 2'b01);
      @(negedge clk);
      chk("R9 done one cycle", 64'(done), 64'd0);
    end else begin
      bcnt = 1;
      while (busy) begin
        if (mid_start && bcnt == BUSY_C / 2) start = 1;
        @(negedge clk);
        start = 0;
        if (busy) bcnt++;
      end
      chk(mid_start ? "R10 busy length with start" : "R9 busy length", 64'(bcnt), 64'(BUSY_C));
      chk("R9 done pulse", 64'(done), 64'd1);
      @(negedge clk);
    end
  endtask

  task automatic check_results(input string tag);
    for (int d = 0; d < N_DEV; d++) begin
      bit ep = 1, em = 0;
      int ei = 0;
      logic [DQ_W-1:0] ed = '0;
      for (int v = 0; v < N_VEC; v++) begin
        logic [DQ_W-1:0] g = dev_resp(d, gen_vec(v));
        logic [DQ_W-1:0] e = exp_of(gen_vec(v));
        if (g != e && ep) begin ep = 0; ei = v; ed = g ^ e; end
        if (v >= 1 && v <= 2 * N_IN && g == '1) em = 1;
      end
      chk({tag, " R6 pass"}, 64'(pass[d]), 64'(ep));
      chk({tag, " R7 idx"}, 64'(fidx[d*IDX_W +: IDX_W]), 64'(ei));
      chk({tag, " R7 diff"}, 64'(diff[d*DQ_W +: DQ_W]), 64'(ed));
      chk({tag, " R8 miss"}, 64'(miss[d]), 64'(em));
    end
  endtask

  task automatic clean_faults();
    for (int d = 0; d < N_DEV; d++) begin present[d] = 1; s1[d] = '0; s0[d] = '0; end
  endtask

  initial begin
    int seed;
    seed = $urandom(32'h1c7);
    clean_faults();
    repeat (3) @(negedge clk);
    chk("R1 reset pins", {cas_n, cke, cs_n, busy, done}, {1'b1, 1'b1, {N_DEV{1'b1}}, 2'b00});
    chk("R1 reset flags", {vec, pass, miss}, '0);
    rst_ni = 1;
    @(negedge clk);
    chk("R1 idle pins", {cas_n, cke, cs_n, vec}, {1'b1, 1'b1, {N_DEV{1'b1}}, {N_IN{1'b0}}});

    run(1, 0); check_results("clean R5");
    present[1] = 0;
    run(0, 0); check_results("missing dev1");
    clean_faults(); s0[0][31] = 1'b1;
    run(0, 0); check_results("stuck0 dev0 bit31");
    clean_faults(); s1[1][0] = 1'b1;
    run(0, 1); check_results("R10 stuck1 dev1");
    clean_faults();
    run(0, 0); check_results("R10 cleared");
    for (int r = 0; r < 8; r++) begin
      clean_faults();
      for (int d = 0; d < N_DEV; d++) begin
        if ($urandom_range(0, 1)) s1[d][$urandom_range(0, DQ_W-1)] = 1'b1;
        if ($urandom_range(0, 1)) s0[d][$urandom_range(0, DQ_W-1)] = 1'b1;
        present[d] = ($urandom_range(0, 5) != 0);
      end
      run(r == 0, 0); check_results("random");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_NS * 150000);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule